// File: doc/BRIEF.md
# Datapath Memory Port Unit

This block sits between a microprogrammed datapath and two memories. A 32-bit word port is driven from an address register and a data register. An 8-bit byte port is addressed by the program counter and returns an opcode or operand byte into a byte buffer. The datapath loads these registers from its result bus, and the current microinstruction carries three request bits: word read, word write and byte fetch.

A request raised in cycle k takes effect after that cycle's register loads at the closing clock edge. The memory strobe is then high for cycle k+1, using the address and data the registers hold in that cycle. Read results are captured at the end of cycle k+1, so the datapath can use them from cycle k+2 onward. The byte buffer is presented on a 32-bit output, either zero-extended or sign-extended under a select input.

Each port has a small state machine.
- Word machine states: `WS_IDLE`, `WS_READ`, `WS_WRITE`, `WS_FAULT`. The next state depends only on the request bits of the current cycle:
  - read alone goes to `WS_READ`;
  - write alone goes to `WS_WRITE`;
  - both go to `WS_FAULT`;
  - neither goes to `WS_IDLE`.
  Any state can reach any state, so requests may be issued back to back.
- Byte machine states: `BS_IDLE` and `BS_FETCH`. A fetch request goes to `BS_FETCH`; otherwise the machine goes to `BS_IDLE`.

Top module: `mem_port_unit`

## Requirements
- R1: After reset, `mar`, `mdr`, `pc` and `mbr` are zero, and `wmem_rd`, `wmem_wr`, `bmem_rd` and `mem_err` are low.
- R2: A word read requested alone in cycle k raises `wmem_rd` in cycle k+1. The data on `wmem_rdata` in that cycle appears on `mdr` from cycle k+2. A `mar` load made in cycle k is already used for the address.
- R3: `wmem_addr` equals `mar` shifted left by two bits. Its two low bits are zero, and the two top bits of `mar` are dropped.
- R4: A word write requested alone in cycle k raises `wmem_wr` in cycle k+1. It drives `mdr` as it stands after cycle k's loads onto `wmem_wdata`, with the address taken as in R3.
- R5: A fetch requested in cycle k raises `bmem_rd` in cycle k+1, with `bmem_addr` equal to `pc` after cycle k's loads. The byte on `bmem_rdata` appears on `mbr` from cycle k+2.
- R6: When `mbr_sext` is 0, `mbr_bus` is `mbr` in bits 7..0 with zeros in bits 31..8. For example, 0xAA gives 0x000000AA.
- R7: When `mbr_sext` is 1, `mbr_bus` is `mbr` in bits 7..0 with bit 7 copied into bits 31..8.
- R8: If read and write are requested in the same cycle, `mem_err` is high in the next cycle. Neither `wmem_rd` nor `wmem_wr` rises, and `mdr` keeps its value.
- R9: In the cycle a word read completes, the read data is written into `mdr` even if `ld_mdr` is also high. The result-bus value is discarded.
- R10: A fetch and a word read or write requested in the same cycle both complete with the timing of R2, R4 and R5.
- R11: A cycle with no word request is followed by a cycle with `wmem_rd`, `wmem_wr` and `mem_err` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c_bus | input | 32 | Datapath result bus |
| ld_mar | input | 1 | Load word address register from `c_bus` |
| ld_mdr | input | 1 | Load word data register from `c_bus` |
| ld_pc | input | 1 | Load program counter from `c_bus` |
| rd_req | input | 1 | Word read request |
| wr_req | input | 1 | Word write request |
| fetch_req | input | 1 | Byte fetch request |
| mbr_sext | input | 1 | 1: sign-extend byte buffer on `mbr_bus`; 0: zero-extend |
| mar | output | 32 | Word address register (word index) |
| mdr | output | 32 | Word data register |
| pc | output | 32 | Program counter (byte address) |
| mbr | output | 8 | Byte buffer |
| mbr_bus | output | 32 | Widened byte buffer |
| wmem_addr | output | 32 | Word memory byte address |
| wmem_rd | output | 1 | Word memory read strobe |
| wmem_wr | output | 1 | Word memory write strobe |
| wmem_wdata | output | 32 | Word memory write data |
| wmem_rdata | input | 32 | Word memory read data |
| bmem_addr | output | 32 | Byte memory address |
| bmem_rd | output | 1 | Byte memory read strobe |
| bmem_rdata | input | 8 | Byte memory read data |
| mem_err | output | 1 | Read and write requested together in the previous cycle |

## Verification
Two collisions on the word data register are provoked on purpose:
- A read completes while the datapath is also loading `mdr` from `c_bus` in that same cycle. This is judged by `mdr` two cycles after the request holding the memory word and not the bus value.
- A write is requested in the same instruction that loads `mdr`. This is judged by `wmem_wdata` carrying the freshly loaded value.

Concurrency across the two ports is also provoked, by requesting a fetch in the same cycle as a word read. Both results must land in the same cycle without disturbing each other. The forbidden read-plus-write pair is driven once, and the error flag and silent strobes are checked in the following cycle.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    // word index to byte address: shift by log2(bytes per word)
    localparam int WORD_SHIFT = 2;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_READ  = 2'd1,
        WS_WRITE = 2'd2,
        WS_FAULT = 2'd3
    } word_state_e;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_FETCH = 1'b1
    } byte_state_e;

endpackage

// File: rtl/mpu_word_port.sv
module mpu_word_port
    import mpu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              err
);

    localparam int KEEP_W = DATA_W - WORD_SHIFT;

    word_state_e state_q, state_d;
    logic [DATA_W-1:0] mar_q, mdr_q;

    // next state depends only on this cycle's request bits
    always_comb begin
        unique case ({rd_req, wr_req})
            2'b10:   state_d = WS_READ;
            2'b01:   state_d = WS_WRITE;
            2'b11:   state_d = WS_FAULT;
            default: state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // registers: a completing read wins over a bus load of the data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ld_mar) mar_q <= c_bus;
            if (state_q == WS_READ) mdr_q <= rdata;
            else if (ld_mdr)        mdr_q <= c_bus;
        end
    end

    // outputs decoded from the state
    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        err    = 1'b0;
        unique case (state_q)
            WS_READ:  mem_rd = 1'b1;
            WS_WRITE: mem_wr = 1'b1;
            WS_FAULT: err    = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr  = {mar_q[KEEP_W-1:0], {WORD_SHIFT{1'b0}}};
    assign mem_wdata = mdr_q;
    assign mar       = mar_q;
    assign mdr       = mdr_q;

endmodule

// File: rtl/mpu_byte_port.sv
module mpu_byte_port
    import mpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              ld_pc,
    input  logic              fetch_req,
    input  logic [BYTE_W-1:0] rdata,
    output logic [DATA_W-1:0] pc,
    output logic [BYTE_W-1:0] mbr,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd
);

    byte_state_e state_q, state_d;
    logic [DATA_W-1:0] pc_q;
    logic [BYTE_W-1:0] mbr_q;

    always_comb begin
        unique case (fetch_req)
            1'b1:    state_d = BS_FETCH;
            default: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mbr_q <= '0;
        end else begin
            if (ld_pc)               pc_q  <= c_bus;
            if (state_q == BS_FETCH) mbr_q <= rdata;
        end
    end

    always_comb begin
        mem_rd = 1'b0;
        unique case (state_q)
            BS_FETCH: mem_rd = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr = pc_q;
    assign pc       = pc_q;
    assign mbr      = mbr_q;

endmodule

// File: rtl/mpu_widen.sv
module mpu_widen #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sext,
    output logic [DATA_W-1:0] word_out
);

    localparam int EXT_W = DATA_W - BYTE_W;

    generate
        if (EXT_W > 0) begin : g_ext
            logic fill;
            assign fill     = sext & byte_in[BYTE_W-1];
            assign word_out = {{EXT_W{fill}}, byte_in};
        end else begin : g_pass
            assign word_out = byte_in[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/mem_port_unit.sv
module mem_port_unit #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              ld_pc,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              fetch_req,
    input  logic              mbr_sext,
    output logic [DATA_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] pc,
    output logic [BYTE_W-1:0] mbr,
    output logic [DATA_W-1:0] mbr_bus,
    output logic [DATA_W-1:0] wmem_addr,
    output logic              wmem_rd,
    output logic              wmem_wr,
    output logic [DATA_W-1:0] wmem_wdata,
    input  logic [DATA_W-1:0] wmem_rdata,
    output logic [DATA_W-1:0] bmem_addr,
    output logic              bmem_rd,
    input  logic [BYTE_W-1:0] bmem_rdata,
    output logic              mem_err
);

    mpu_word_port #(.DATA_W(DATA_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_bus     (c_bus),
        .ld_mar    (ld_mar),
        .ld_mdr    (ld_mdr),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rdata     (wmem_rdata),
        .mar       (mar),
        .mdr       (mdr),
        .mem_addr  (wmem_addr),
        .mem_rd    (wmem_rd),
        .mem_wr    (wmem_wr),
        .mem_wdata (wmem_wdata),
        .err       (mem_err)
    );

    mpu_byte_port #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_byte (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_bus     (c_bus),
        .ld_pc     (ld_pc),
        .fetch_req (fetch_req),
        .rdata     (bmem_rdata),
        .pc        (pc),
        .mbr       (mbr),
        .mem_addr  (bmem_addr),
        .mem_rd    (bmem_rd)
    );

    mpu_widen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_widen (
        .byte_in  (mbr),
        .sext     (mbr_sext),
        .word_out (mbr_bus)
    );

endmodule

// File: rtl/mem_port_unit_chk.sv
module mem_port_unit_chk #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_req,
    input logic              fetch_req,
    input logic              mbr_sext,
    input logic [DATA_W-1:0] mar,
    input logic [DATA_W-1:0] mdr,
    input logic [BYTE_W-1:0] mbr,
    input logic [DATA_W-1:0] mbr_bus,
    input logic [DATA_W-1:0] wmem_addr,
    input logic              wmem_rd,
    input logic              wmem_wr,
    input logic [DATA_W-1:0] wmem_rdata,
    input logic              bmem_rd,
    input logic [BYTE_W-1:0] bmem_rdata,
    input logic              mem_err
);

    AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req) |=> (wmem_rd && !wmem_wr)); // R2

    AST_RD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wmem_rd |=> (mdr == $past(wmem_rdata))); // R9

    AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wmem_rd || wmem_wr) |-> (wmem_addr[1:0] == 2'b00 && wmem_addr[DATA_W-1:2] == mar[DATA_W-3:0])); // R3

    AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req) |=> (wmem_wr && !wmem_rd)); // R4

    AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        bmem_rd |=> (mbr == $past(bmem_rdata))); // R5

    AST_FETCH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> bmem_rd); // R10

    AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !mbr_sext |-> (mbr_bus[DATA_W-1:BYTE_W] == '0 && mbr_bus[BYTE_W-1:0] == mbr)); // R6

    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        mbr_sext |-> (mbr_bus[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){mbr[BYTE_W-1]}})); // R7

    AST_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req) |=> (mem_err && !wmem_rd && !wmem_wr)); // R8

    AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_err |=> $stable(mdr) || $past(wmem_rd)); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wmem_rd, wmem_wr, mem_err}) <= 1); // R8

    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !wr_req) |=> (!wmem_rd && !wmem_wr && !mem_err)); // R11

endmodule

bind mem_port_unit mem_port_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .fetch_req  (fetch_req),
    .mbr_sext   (mbr_sext),
    .mar        (mar),
    .mdr        (mdr),
    .mbr        (mbr),
    .mbr_bus    (mbr_bus),
    .wmem_addr  (wmem_addr),
    .wmem_rd    (wmem_rd),
    .wmem_wr    (wmem_wr),
    .wmem_rdata (wmem_rdata),
    .bmem_rd    (bmem_rd),
    .bmem_rdata (bmem_rdata),
    .mem_err    (mem_err)
);

// File: tb/tb_mem_port_unit.sv
module tb_mem_port_unit;

    localparam int CLK_PERIOD = 10;

    // scoreboard item kinds
    localparam int K_RDSTB = 0;
    localparam int K_WRSTB = 1;
    localparam int K_ERR   = 2;
    localparam int K_QUIET = 3;
    localparam int K_FSTB  = 4;
    localparam int K_MDR   = 5;
    localparam int K_MBR   = 6;
    localparam int K_BUS   = 7;

    typedef struct {
        int          kind;
        int          due;
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] c_bus = '0;
    logic        ld_mar = 1'b0, ld_mdr = 1'b0, ld_pc = 1'b0;
    logic        rd_req = 1'b0, wr_req = 1'b0, fetch_req = 1'b0, mbr_sext = 1'b0;
    logic [31:0] mar, mdr, pc, mbr_bus, wmem_addr, wmem_wdata, wmem_rdata, bmem_addr;
    logic [7:0]  mbr, bmem_rdata;
    logic        wmem_rd, wmem_wr, bmem_rd, mem_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    item_t       sb_q[$];
    logic [31:0] wmem [16];   // memory model
    logic [31:0] shadow [16]; // expected contents

    // bench-side model state (after each issued cycle)
    logic [31:0] mar_s = '0, mdr_s = '0, pc_s = '0;
    logic [7:0]  mbr_s = '0;
    bit          rd_pend = 1'b0, fe_pend = 1'b0;
    logic [31:0] rd_val = '0;
    logic [7:0]  fe_val = '0;

    mem_port_unit dut (
        .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req), .mbr_sext(mbr_sext),
        .mar(mar), .mdr(mdr), .pc(pc), .mbr(mbr), .mbr_bus(mbr_bus),
        .wmem_addr(wmem_addr), .wmem_rd(wmem_rd), .wmem_wr(wmem_wr),
        .wmem_wdata(wmem_wdata), .wmem_rdata(wmem_rdata),
        .bmem_addr(bmem_addr), .bmem_rd(bmem_rd), .bmem_rdata(bmem_rdata),
        .mem_err(mem_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural memories
    assign wmem_rdata = wmem[wmem_addr[5:2]];
    assign bmem_rdata = bmem_addr[7:0] ^ 8'hC3;

    always @(posedge clk) begin
        if (wmem_wr) wmem[wmem_addr[5:2]] <= wmem_wdata;
        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int due, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
        item_t it;
        it.kind = kind; it.due = due; it.a = a; it.d = d; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // driver: one microinstruction per call, expectations derived from the requirements
    task automatic issue(input bit lm, input bit lmdr, input bit lpc, input logic [31:0] cv,
                         input bit rd, input bit wr, input bit fe, input bit sx, input string tag);
        logic [31:0] nmdr;
        @(negedge clk);
        ld_mar = lm; ld_mdr = lmdr; ld_pc = lpc; c_bus = cv;
        rd_req = rd; wr_req = wr; fetch_req = fe; mbr_sext = sx;
        // widened byte buffer in this cycle (R6, R7)
        push(K_BUS, cyc, '0, sx ? {{24{mbr_s[7]}}, mbr_s} : {24'h0, mbr_s}, sx ? "R7 sign" : "R6 zero");
        // register values after this cycle's edge
        if (lm) mar_s = cv;
        if (lpc) pc_s = cv;
        nmdr = rd_pend ? rd_val : (lmdr ? cv : mdr_s); // R9 read wins
        mdr_s = nmdr;
        if (fe_pend) mbr_s = fe_val;
        rd_pend = 1'b0;
        fe_pend = 1'b0;
        if (rd && !wr) begin
            rd_val  = shadow[mar_s[3:0]];
            rd_pend = 1'b1;
            push(K_RDSTB, cyc + 1, {mar_s[29:0], 2'b00}, '0, {tag, " R2 R3 strobe"});
            push(K_MDR, cyc + 2, '0, rd_val, {tag, " R2 data"});
        end else if (wr && !rd) begin
            shadow[mar_s[3:0]] = mdr_s;
            push(K_WRSTB, cyc + 1, {mar_s[29:0], 2'b00}, mdr_s, {tag, " R4 write"});
        end else if (rd && wr) begin
            push(K_ERR, cyc + 1, '0, '0, {tag, " R8 flag"});
            push(K_MDR, cyc + 2, '0, mdr_s, {tag, " R8 mdr kept"});
        end else begin
            push(K_QUIET, cyc + 1, '0, '0, {tag, " R11 quiet"});
        end
        if (fe) begin
            fe_val  = pc_s[7:0] ^ 8'hC3;
            fe_pend = 1'b1;
            push(K_FSTB, cyc + 1, pc_s, '0, {tag, " R5 strobe"});
            push(K_MBR, cyc + 2, '0, {24'h0, fe_val}, {tag, " R5 byte"});
        end
    endtask

    // monitor: pops items falling due in this cycle
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                item_t it;
                it = sb_q[i];
                if (it.due <= cyc) begin
                    if (it.due < cyc) check(1'b0, {it.tag, " missed"}, '0, '0);
                    else begin
                        case (it.kind)
                            K_RDSTB: check(wmem_rd && !wmem_wr && wmem_addr == it.a, it.tag, wmem_addr, it.a);
                            K_WRSTB: check(wmem_wr && !wmem_rd && wmem_addr == it.a && wmem_wdata == it.d,
                                           it.tag, wmem_wdata, it.d);
                            K_ERR:   check(mem_err && !wmem_rd && !wmem_wr, it.tag,
                                           {29'h0, mem_err, wmem_rd, wmem_wr}, 32'h4);
                            K_QUIET: check(!mem_err && !wmem_rd && !wmem_wr, it.tag,
                                           {29'h0, mem_err, wmem_rd, wmem_wr}, 32'h0);
                            K_FSTB:  check(bmem_rd && bmem_addr == it.a, it.tag, bmem_addr, it.a);
                            K_MDR:   check(mdr == it.d, it.tag, mdr, it.d);
                            K_MBR:   check({24'h0, mbr} == it.d, it.tag, {24'h0, mbr}, it.d);
                            default: check(mbr_bus == it.d, it.tag, mbr_bus, it.d);
                        endcase
                    end
                    sb_q.delete(i);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            wmem[i]   = 32'hA000_0000 + i * 32'h111;
            shadow[i] = 32'hA000_0000 + i * 32'h111;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(mar == 0 && mdr == 0 && pc == 0 && mbr == 0, "R1 registers", mar | mdr | pc, 0);
        check(!wmem_rd && !wmem_wr && !bmem_rd && !mem_err, "R1 strobes",
              {28'h0, wmem_rd, wmem_wr, bmem_rd, mem_err}, 0);

        // R2: read with address loaded in the same instruction
        issue(1, 0, 0, 32'd3, 1, 0, 0, 0, "rd3");
        // R9: datapath loads mdr while the read completes
        issue(0, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, "r9_collide");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        // R4: write with mdr and mar loaded in the same instruction, then read back
        issue(1, 1, 0, 32'd5, 0, 1, 0, 0, "wr5");
        issue(0, 1, 0, 32'h1234_5678, 0, 0, 0, 0, "ldmdr");
        issue(0, 0, 0, 32'h0, 0, 1, 0, 0, "wr5b");
        issue(0, 0, 0, 32'h0, 1, 0, 0, 0, "rd5");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        // R3: high bits of the word index are dropped
        issue(1, 0, 0, 32'hC000_0007, 1, 0, 0, 0, "r3_high");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        // R8: read and write together
        issue(0, 0, 0, 32'h0, 1, 1, 0, 0, "r8_both");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        // R5 + R10: fetch alongside a word read; byte 0x10^0xC3 = 0xD3
        issue(1, 0, 1, 32'h0000_0010, 1, 0, 1, 0, "r10_pair");
        issue(1, 0, 1, 32'h0000_003C, 0, 0, 1, 0, "fe3c");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 1, "r7_neg");   // mbr = 0xD3
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "r6_ff");    // mbr = 0xFF
        issue(0, 0, 0, 32'h0, 0, 0, 0, 1, "r7_ff");
        issue(1, 0, 1, 32'h0000_0069, 0, 0, 1, 0, "fe69"); // byte 0xAA
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "idle");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "r6_aa");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 1, "r7_aa");
        issue(1, 0, 1, 32'h0000_0083, 0, 1, 1, 1, "r10_wr"); // byte 0x40, write with fetch
        issue(0, 0, 0, 32'h0, 0, 0, 0, 1, "idle");
        issue(0, 0, 0, 32'h0, 0, 0, 0, 1, "r7_pos");
        repeat (3) issue(0, 0, 0, 32'h0, 0, 0, 0, 0, "drain");
        @(negedge clk);
        #2;
        check(sb_q.size() == 0, "scoreboard empty", sb_q.size(), 0);
        finish_run();
    end

endmodule